// File: doc/BRIEF.md
# Sixteen-Bit Single-Cycle Processor Core

This block is a small processor that finishes one instruction in every clock cycle. It holds a 16-bit program counter and four general registers. On each cycle it fetches the word that an external instruction port returns, decodes it, and reads up to two registers. It then computes a result through a shared arithmetic unit and commits that result on the next rising edge.

The core drives the address of an instruction memory and of a data memory, and both memories live outside the block. Each address selects a whole 16-bit word, so the program counter moves by one per instruction. Reads from both memories are combinational in the same cycle. Data writes are taken by the memory at the clock edge.

A separate output port carries display commands, each one an index and a 16-bit value, so that external indicator logic can latch them.

Top module: `cpu16_core`

## Requirements
- R1: While reset is low the program counter and all four registers are zero. Just after reset, displaying any register yields 0x0000, and the first fetch address is 0x0000.
- R2: Instruction fields are: opcode [15:12], rs [11:10], rt [9:8], 8-bit immediate or offset [7:0]. For R-type instructions, rd is [7:6] and funct is [2:0]. Opcodes are: 0 R-type, 1 display, 2 load-upper, 3 or-immediate, 4 add-immediate, 5 and-immediate, 6 load, 7 store, 8 jump, 9 branch-equal, 10 branch-not-equal. The word 0x0000 and any opcode from 11 to 15 change no register, no memory, no display and no control flow.
- R3: R-type funct values give rd = rs op rt as follows: 0 OR, 1 AND, 2 add, 3 subtract, 4 shift left, 5 logical shift right, 6 arithmetic shift right, 7 signed less-than (result 1 or 0). Shifts use rt[3:0] as the amount.
- R4: Load-upper writes rt with imm << 8. Or-immediate and and-immediate combine rs with the zero-extended immediate. Add-immediate adds the sign-extended immediate. All of these write rt.
- R5: Load writes rt with MEM[rs + sext(imm)]. Store raises the data write enable for that one cycle, with address rs + sext(imm) and data rt.
- R6: The display instruction raises the display strobe for one cycle, with index = imm[7:0] and data = rs. The display strobe and the data write enable are never high together.
- R7: Every non-control instruction advances the PC by exactly one. The instruction address always equals the PC.
- R8: Jump loads the PC with {PC[15:12], instr[11:0]}, with no low-order zeros appended.
- R9: Branch-equal sets PC = PC + 1 + sext(offset) when rs equals rt, and PC + 1 otherwise. Branch-not-equal uses the inverse test. An offset of -1 holds the PC in place.
- R10: Register r0 is an ordinary register that can be written and read back.
- R11: A register written by one instruction is seen by the next one. An instruction that reads and writes the same register uses the old value as its operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| imemAddr | output | 16 | Instruction fetch address (the PC) |
| imemData | input | 16 | Instruction word at imemAddr |
| dmemAddr | output | 16 | Data memory address for load and store |
| dmemRdData | input | 16 | Data word read at dmemAddr |
| dmemWrEn | output | 1 | Data write enable, high during a store |
| dmemWrData | output | 16 | Data to write |
| dispWrEn | output | 1 | Display command strobe |
| dispIndex | output | 8 | Display slot index |
| dispData | output | 16 | Value for the display slot |

## Verification
Two functions can meet in one cycle: the register-file read that feeds an operand, and the write-back into the same register. Instructions such as `addi r1,r1,1` run back to back, followed by `add r1,r1,r1`, to provoke this. The result is judged by displaying r1 afterwards and comparing it with a value computed from the old-operand rule. A backward `bne` loop also compares a register that its own loop body just decremented, so a wrong read-during-write order shows up as a wrong count of display events.

// File: rtl/cpu16_pkg.sv
`timescale 1ns/1ps
package cpu16_pkg;
  localparam int DW     = 16;          // datapath width
  localparam int OPW    = 4;           // opcode width
  localparam int REGN   = 4;           // register count
  localparam int RAW    = $clog2(REGN);
  localparam int IMMW   = 8;           // immediate / offset width
  localparam int JW     = 12;          // jump target width
  localparam int FW     = 3;           // funct width actually decoded
  localparam int RS_LSB = 10;
  localparam int RT_LSB = 8;
  localparam int RD_LSB = 6;
  localparam int BODYW  = DW - OPW;

  typedef enum logic [OPW-1:0] {
    OP_RTYPE = 4'd0, OP_DISP = 4'd1, OP_LUI = 4'd2, OP_ORI = 4'd3,
    OP_ADDI  = 4'd4, OP_ANDI = 4'd5, OP_LW  = 4'd6, OP_SW  = 4'd7,
    OP_JMP   = 4'd8, OP_BEQ  = 4'd9, OP_BNE = 4'd10
  } opcode_e;

  // first eight values line up with the R-type funct code
  typedef enum logic [3:0] {
    ALU_OR = 4'd0, ALU_AND = 4'd1, ALU_ADD = 4'd2, ALU_SUB = 4'd3,
    ALU_SLL = 4'd4, ALU_SRL = 4'd5, ALU_SRA = 4'd6, ALU_SLT = 4'd7,
    ALU_LUI = 4'd8
  } alu_op_e;

  typedef struct packed {
    logic    regWrite;
    logic    dstIsRd;
    logic    useImm;
    logic    immSigned;
    logic    memToReg;
    logic    memWrite;
    logic    dispWrite;
    logic    jump;
    logic    branch;
    logic    branchNe;
    alu_op_e aluOp;
  } ctrl_t;
endpackage

// File: rtl/cpu16_alu.sv
`timescale 1ns/1ps
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  alu_op_e      op,
  output logic [W-1:0] result
);
  localparam int SHW = $clog2(W);
  localparam int UPSHIFT = W / 2;

  logic [SHW-1:0] shAmt;
  assign shAmt = opB[SHW-1:0];

  always_comb begin
    unique case (op)
      ALU_OR:  result = opA | opB;
      ALU_AND: result = opA & opB;
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_SLL: result = opA << shAmt;
      ALU_SRL: result = opA >> shAmt;
      ALU_SRA: result = $unsigned($signed(opA) >>> shAmt);
      ALU_SLT: result = {{(W-1){1'b0}}, ($signed(opA) < $signed(opB))};
      ALU_LUI: result = opB << UPSHIFT;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/cpu16_control.sv
`timescale 1ns/1ps
module cpu16_control
  import cpu16_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  input  logic [FW-1:0]  funct,
  output ctrl_t          ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.aluOp = ALU_OR;
    case (opcode)
      OP_RTYPE: begin
        ctrl.regWrite = 1'b1;
        ctrl.dstIsRd  = 1'b1;
        ctrl.aluOp    = alu_op_e'({1'b0, funct});
      end
      OP_DISP: ctrl.dispWrite = 1'b1;
      OP_LUI: begin
        ctrl.regWrite = 1'b1;
        ctrl.useImm   = 1'b1;
        ctrl.aluOp    = ALU_LUI;
      end
      OP_ORI: begin
        ctrl.regWrite = 1'b1;
        ctrl.useImm   = 1'b1;
        ctrl.aluOp    = ALU_OR;
      end
      OP_ADDI: begin
        ctrl.regWrite  = 1'b1;
        ctrl.useImm    = 1'b1;
        ctrl.immSigned = 1'b1;
        ctrl.aluOp     = ALU_ADD;
      end
      OP_ANDI: begin
        ctrl.regWrite = 1'b1;
        ctrl.useImm   = 1'b1;
        ctrl.aluOp    = ALU_AND;
      end
      OP_LW: begin
        ctrl.regWrite  = 1'b1;
        ctrl.useImm    = 1'b1;
        ctrl.immSigned = 1'b1;
        ctrl.memToReg  = 1'b1;
        ctrl.aluOp     = ALU_ADD;
      end
      OP_SW: begin
        ctrl.useImm    = 1'b1;
        ctrl.immSigned = 1'b1;
        ctrl.memWrite  = 1'b1;
        ctrl.aluOp     = ALU_ADD;
      end
      OP_JMP: ctrl.jump = 1'b1;
      OP_BEQ: ctrl.branch = 1'b1;
      OP_BNE: begin
        ctrl.branch   = 1'b1;
        ctrl.branchNe = 1'b1;
      end
      default: ;
    endcase
  end

  // R2: opcodes above the map leave every state element alone
  always_comb begin
    if (opcode > 4'd10) begin
      assert_idle_opcode_R2: assert (!ctrl.regWrite && !ctrl.memWrite &&
                                     !ctrl.dispWrite && !ctrl.jump && !ctrl.branch);
    end
  end
endmodule

// File: rtl/cpu16_datapath.sv
`timescale 1ns/1ps
module cpu16_datapath
  import cpu16_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrl,
  input  logic [BODYW-1:0] instrBody,
  output logic [DW-1:0]    pc,
  output logic [DW-1:0]    dmemAddr,
  input  logic [DW-1:0]    dmemRdData,
  output logic             dmemWrEn,
  output logic [DW-1:0]    dmemWrData,
  output logic             dispWrEn,
  output logic [IMMW-1:0]  dispIndex,
  output logic [DW-1:0]    dispData
);
  logic [DW-1:0]   regQ [REGN];
  logic [DW-1:0]   pcQ;
  logic [RAW-1:0]  rsIdx, rtIdx, rdIdx, dstIdx;
  logic [IMMW-1:0] imm;
  logic [DW-1:0]   rsVal, rtVal, immZext, immSext, aluB, aluRes, wbData;
  logic [DW-1:0]   pcPlus1, brTarget, jmpTarget, pcNext;
  logic            taken;

  assign rsIdx  = instrBody[RS_LSB +: RAW];
  assign rtIdx  = instrBody[RT_LSB +: RAW];
  assign rdIdx  = instrBody[RD_LSB +: RAW];
  assign imm    = instrBody[IMMW-1:0];
  assign dstIdx = ctrl.dstIsRd ? rdIdx : rtIdx;

  assign rsVal   = regQ[rsIdx];
  assign rtVal   = regQ[rtIdx];
  assign immZext = {{(DW-IMMW){1'b0}}, imm};
  assign immSext = {{(DW-IMMW){imm[IMMW-1]}}, imm};
  assign aluB    = ctrl.useImm ? (ctrl.immSigned ? immSext : immZext) : rtVal;

  cpu16_alu #(.W(DW)) u_alu (
    .opA(rsVal), .opB(aluB), .op(ctrl.aluOp), .result(aluRes)
  );

  assign wbData = ctrl.memToReg ? dmemRdData : aluRes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REGN; i++) regQ[i] <= '0;
    end else if (ctrl.regWrite) begin
      regQ[dstIdx] <= wbData;
    end
  end

  // next-PC selection
  assign pcPlus1   = pcQ + 1'b1;
  assign brTarget  = pcPlus1 + immSext;
  assign jmpTarget = {pcQ[DW-1:JW], instrBody[JW-1:0]};
  assign taken     = ctrl.branch && ((rsVal == rtVal) ^ ctrl.branchNe);
  assign pcNext    = ctrl.jump ? jmpTarget : (taken ? brTarget : pcPlus1);

  always_ff @(posedge clk) begin
    if (!rstN) pcQ <= '0;
    else       pcQ <= pcNext;
  end

  assign pc         = pcQ;
  assign dmemAddr   = aluRes;
  assign dmemWrData = rtVal;
  assign dmemWrEn   = ctrl.memWrite;
  assign dispWrEn   = ctrl.dispWrite;
  assign dispIndex  = imm;
  assign dispData   = rsVal;

  assert_seq_pc_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.jump && !ctrl.branch) |=> (pcQ == $past(pcQ) + 1'b1));

  assert_jump_pc_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.jump |=> (pcQ == {$past(pcQ[DW-1:JW]), $past(instrBody[JW-1:0])}));

  assert_branch_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.branch && ((rsVal == rtVal) == ctrl.branchNe)) |=> (pcQ == $past(pcQ) + 1'b1));

  assert_writeback_R11: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.regWrite |=> (regQ[$past(dstIdx)] == $past(wbData)));
endmodule

// File: rtl/cpu16_core.sv
`timescale 1ns/1ps
module cpu16_core
  import cpu16_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  output logic [DW-1:0]   imemAddr,
  input  logic [DW-1:0]   imemData,
  output logic [DW-1:0]   dmemAddr,
  input  logic [DW-1:0]   dmemRdData,
  output logic            dmemWrEn,
  output logic [DW-1:0]   dmemWrData,
  output logic            dispWrEn,
  output logic [IMMW-1:0] dispIndex,
  output logic [DW-1:0]   dispData
);
  ctrl_t ctrl;

  cpu16_control u_ctrl (
    .opcode(imemData[DW-1 -: OPW]),
    .funct (imemData[FW-1:0]),
    .ctrl  (ctrl)
  );

  cpu16_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .instrBody (imemData[BODYW-1:0]),
    .pc        (imemAddr),
    .dmemAddr  (dmemAddr),
    .dmemRdData(dmemRdData),
    .dmemWrEn  (dmemWrEn),
    .dmemWrData(dmemWrData),
    .dispWrEn  (dispWrEn),
    .dispIndex (dispIndex),
    .dispData  (dispData)
  );

  assert_disp_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(dispWrEn && dmemWrEn));
endmodule

// File: tb/cpu16_core_test.sv
`timescale 1ns/1ps
module cpu16_core_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] imemAddr, imemData, dmemAddr, dmemRdData, dmemWrData, dispData;
  logic        dmemWrEn, dispWrEn;
  logic [7:0]  dispIndex;

  always #5 clk = ~clk;

  cpu16_core uut (
    .clk(clk), .rstN(rstN), .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemRdData(dmemRdData), .dmemWrEn(dmemWrEn),
    .dmemWrData(dmemWrData), .dispWrEn(dispWrEn), .dispIndex(dispIndex),
    .dispData(dispData)
  );

  logic [15:0] rom [128];
  logic [15:0] ram [64];
  assign imemData   = rom[imemAddr[6:0]];
  assign dmemRdData = ram[dmemAddr[5:0]];
  always @(posedge clk) if (dmemWrEn) ram[dmemAddr[5:0]] <= dmemWrData;

  int nRun = 0, nFail = 0, pcB = 0, haltAddr = 0;
  bit running = 1'b0;
  logic        qMem [$];
  logic [15:0] qA [$];
  logic [15:0] qD [$];
  string       qReq [$];

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] iw(input logic [3:0] op, input logic [1:0] rs,
                                     input logic [1:0] rt, input logic [7:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [15:0] rw(input logic [1:0] rs, input logic [1:0] rt,
                                     input logic [1:0] rd, input logic [2:0] f);
    return {4'h0, rs, rt, rd, 3'b000, f};
  endfunction

  task automatic emit(input logic [15:0] w);
    rom[pcB[6:0]] = w;
    pcB++;
  endtask

  // driver: emits a display instruction and pushes its expected event
  task automatic showReg(input logic [1:0] rs, input logic [7:0] idx,
                         input logic [15:0] d, input string req);
    emit(iw(4'd1, rs, 2'd0, idx));
    qMem.push_back(1'b0); qA.push_back({8'h00, idx}); qD.push_back(d); qReq.push_back(req);
  endtask

  task automatic expStore(input logic [15:0] a, input logic [15:0] d, input string req);
    qMem.push_back(1'b1); qA.push_back(a); qD.push_back(d); qReq.push_back(req);
  endtask

  // monitor: pops and compares every display or store event
  logic        mKind;
  logic [15:0] mA, mD;
  string       mReq;
  always @(negedge clk) begin
    if (running && rstN) begin
      if (dispWrEn && dmemWrEn) begin
        nRun++; nFail++;
        $display("FAIL R6: actual both strobes high expected at most one");
      end else if (dispWrEn || dmemWrEn) begin
        if (qA.size() == 0) begin
          nRun++; nFail++;
          $display("FAIL R2: actual unexpected event idx/addr %h data %h expected none",
                   dmemWrEn ? dmemAddr : {8'h00, dispIndex}, dmemWrEn ? dmemWrData : dispData);
        end else begin
          mKind = qMem.pop_front(); mA = qA.pop_front(); mD = qD.pop_front(); mReq = qReq.pop_front();
          check({mReq, " kind"}, {15'd0, dmemWrEn}, {15'd0, mKind});
          check({mReq, " addr"}, dmemWrEn ? dmemAddr : {8'h00, dispIndex}, mA);
          check({mReq, " data"}, dmemWrEn ? dmemWrData : dispData, mD);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int jmpTo;
    int loopTop;
    rstN = 1'b0;
    for (int i = 0; i < 128; i++) rom[i] = 16'h0000;
    for (int i = 0; i < 64; i++) ram[i] = 16'h0000;
    ram[20] = 16'hBEEF;

    // ---- program and expectations ----
    emit(16'h0000);                              // nop at reset vector (R2)
    showReg(2'd0, 8'h00, 16'h0000, "R1 r0 reset");
    showReg(2'd3, 8'h01, 16'h0000, "R1 r3 reset");
    emit(16'h0000);
    emit(iw(4'd2, 2'd0, 2'd0, 8'h12));           // lui r0 -> 0x1200
    emit(iw(4'd3, 2'd0, 2'd0, 8'h34));           // ori r0 -> 0x1234
    showReg(2'd0, 8'h02, 16'h1234, "R10 r0 writable / R4 lui+ori");
    emit(iw(4'd4, 2'd0, 2'd1, 8'hFF));           // addi r1 = r0 - 1
    showReg(2'd1, 8'h03, 16'h1233, "R4 addi sign-ext");
    emit(iw(4'd5, 2'd0, 2'd2, 8'hCC));           // andi r2 = 0x0004
    showReg(2'd2, 8'h04, 16'h0004, "R4 andi zero-ext");
    emit(16'hBEFF); emit(16'hCAAA); emit(16'hDFFF); emit(16'hE5A5); emit(16'hFFFF);
    showReg(2'd0, 8'h05, 16'h1234, "R2 unused opcodes r0");
    showReg(2'd1, 8'h06, 16'h1233, "R2 unused opcodes r1");
    showReg(2'd2, 8'h07, 16'h0004, "R2 unused opcodes r2");
    showReg(2'd3, 8'h08, 16'h0000, "R2 unused opcodes r3");
    emit(rw(2'd1, 2'd2, 2'd3, 3'd0)); showReg(2'd3, 8'h10, 16'h1237, "R3 or");
    emit(rw(2'd0, 2'd1, 2'd3, 3'd1)); showReg(2'd3, 8'h11, 16'h1230, "R3 and");
    emit(rw(2'd0, 2'd1, 2'd3, 3'd2)); showReg(2'd3, 8'h12, 16'h2467, "R3 add");
    emit(rw(2'd2, 2'd0, 2'd3, 3'd3)); showReg(2'd3, 8'h13, 16'hEDD0, "R3 sub");
    emit(rw(2'd0, 2'd2, 2'd3, 3'd4)); showReg(2'd3, 8'h14, 16'h2340, "R3 sllv");
    emit(rw(2'd0, 2'd2, 2'd3, 3'd5)); showReg(2'd3, 8'h15, 16'h0123, "R3 srlv");
    emit(rw(2'd2, 2'd1, 2'd3, 3'd4)); showReg(2'd3, 8'h16, 16'h0020, "R3 shift uses rt[3:0]");
    emit(iw(4'd2, 2'd0, 2'd0, 8'h80));           // r0 = 0x8000
    emit(rw(2'd0, 2'd2, 2'd3, 3'd5)); showReg(2'd3, 8'h17, 16'h0800, "R3 srlv negative");
    emit(rw(2'd0, 2'd2, 2'd3, 3'd6)); showReg(2'd3, 8'h18, 16'hF800, "R3 srav negative");
    emit(rw(2'd0, 2'd2, 2'd3, 3'd7)); showReg(2'd3, 8'h19, 16'h0001, "R3 slt true");
    emit(rw(2'd2, 2'd0, 2'd3, 3'd7)); showReg(2'd3, 8'h1A, 16'h0000, "R3 slt false");
    emit(iw(4'd2, 2'd0, 2'd1, 8'h00));
    emit(iw(4'd3, 2'd1, 2'd1, 8'h10));           // r1 = 0x0010
    emit(iw(4'd7, 2'd1, 2'd0, 8'hFE));           // sw r0 -> MEM[0x000E]
    expStore(16'h000E, 16'h8000, "R5 store");
    emit(iw(4'd6, 2'd1, 2'd3, 8'hFE));           // lw r3 <- MEM[0x000E]
    showReg(2'd3, 8'h20, 16'h8000, "R5 load after store");
    emit(iw(4'd6, 2'd1, 2'd3, 8'h04));           // lw r3 <- MEM[0x0014]
    showReg(2'd3, 8'h21, 16'hBEEF, "R5 load preset");
    emit(iw(4'd4, 2'd1, 2'd1, 8'h01));
    emit(iw(4'd4, 2'd1, 2'd1, 8'h01));
    showReg(2'd1, 8'h22, 16'h0012, "R11 back-to-back addi");
    emit(rw(2'd1, 2'd1, 2'd1, 3'd2));
    showReg(2'd1, 8'h23, 16'h0024, "R11 read old value");
    emit(iw(4'd2, 2'd0, 2'd3, 8'h00));
    emit(iw(4'd3, 2'd3, 2'd3, 8'h04));           // r3 = 4 = r2
    emit(iw(4'd9, 2'd2, 2'd3, 8'h01));           // beq taken: skip next
    emit(iw(4'd1, 2'd0, 2'd0, 8'h7F));
    emit(iw(4'd10, 2'd2, 2'd3, 8'h01));          // bne not taken
    showReg(2'd2, 8'h30, 16'h0004, "R9 bne fall-through");
    emit(iw(4'd9, 2'd2, 2'd1, 8'h01));           // beq not taken
    showReg(2'd1, 8'h31, 16'h0024, "R9 beq fall-through");
    emit(iw(4'd10, 2'd2, 2'd1, 8'h01));          // bne taken: skip next
    emit(iw(4'd1, 2'd0, 2'd0, 8'h7E));
    emit(iw(4'd2, 2'd0, 2'd2, 8'h00));           // r2 = 0
    emit(iw(4'd2, 2'd0, 2'd3, 8'h00));
    emit(iw(4'd3, 2'd3, 2'd3, 8'h03));           // r3 = 3
    loopTop = pcB;
    emit(iw(4'd4, 2'd3, 2'd3, 8'hFF));
    emit(iw(4'd1, 2'd3, 2'd0, 8'h40));
    for (int k = 2; k >= 0; k--) begin
      qMem.push_back(1'b0); qA.push_back(16'h0040); qD.push_back(16'(k)); qReq.push_back("R9 backward loop");
    end
    emit(iw(4'd10, 2'd3, 2'd2, 8'(loopTop - (pcB + 1))));
    jmpTo = pcB + 2;
    emit({4'h8, 12'(jmpTo)});                    // jump over next word (R8)
    emit(iw(4'd1, 2'd0, 2'd0, 8'h7D));
    haltAddr = pcB;
    emit(iw(4'd9, 2'd0, 2'd0, 8'hFF));           // halt: beq r0,r0,-1

    // ---- reset state ----
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset PC", imemAddr, 16'h0000);
    check("R1 reset no display", {15'd0, dispWrEn}, 16'h0000);
    check("R1 reset no store", {15'd0, dmemWrEn}, 16'h0000);
    rstN = 1'b1;
    running = 1'b1;
    @(negedge clk);
    check("R7 PC step after nop", imemAddr, 16'h0001);
    repeat (300) @(negedge clk);
    check("R9 halt holds PC", imemAddr, 16'(haltAddr));
    @(negedge clk);
    check("R9 halt still held", imemAddr, 16'(haltAddr));
    check("R7 all expected events seen", 16'(qA.size()), 16'h0000);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule